// File: doc/BRIEF.md
# Load-Use Register Lock Scoreboard

This block sits at the issue point of a simple in-order integer pipeline and tracks which architectural registers are still waiting on data from memory. When a load is accepted at issue, its target register is marked locked. When the memory side later reports that the load has finished, that register is unlocked again.

Each cycle the block looks at the instruction offered for issue. If neither of its two sources nor its destination is locked, the instruction goes ahead. Independent work therefore keeps flowing past a load that is still in flight. The pipeline is held only when an instruction actually touches a locked register, or when the number of outstanding loads has reached its limit.

The stall output is combinational from the current lock state and the offered instruction. The surrounding pipeline keeps the instruction on the issue port until stall drops.

Top module: `load_lock_scoreboard`

## Requirements
- R1: After reset no register is locked, so any valid instruction sees stall low.
- R2: A load accepted at issue (valid high, stall low, load flag high, destination not 0) locks its destination from the next clock edge on.
- R3: A valid instruction whose sources and destination are all unlocked sees stall low, even while other loads are outstanding.
- R4: A valid instruction whose source A or source B names a locked register sees stall high.
- R5: A valid instruction whose destination names a locked register sees stall high.
- R6: A completion (valid high, index of a locked register) unlocks that register from the next clock edge on.
- R7: Register 0 is never locked. A load targeting it locks nothing, and referencing it never causes a stall.
- R8: When a completion and an accepted load name the same register in the same cycle, the register is locked after the edge.
- R9: With 4 (MAX_PENDING) registers locked, a valid load sees stall high, while a non-load using only unlocked registers sees stall low. Once one of them completes, the load issues.
- R10: Stall is combinational: it is low whenever issue valid is low, and a completion arriving in a cycle does not lower that same cycle's stall.
- R11: A stalled instruction changes no lock state. A stalled load does not lock its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_is_load | input | 1 | The offered instruction is a memory load |
| iss_dst | input | 5 | Destination register index |
| iss_src_a | input | 5 | First source register index |
| iss_src_b | input | 5 | Second source register index |
| cpl_valid | input | 1 | A load completion is reported this cycle |
| cpl_reg | input | 5 | Register index the completing load wrote |
| stall | output | 1 | The offered instruction must be held this cycle |

## Verification
The bench builds the block with its defaults: 32 registers and 4 outstanding loads. With only four loads needed to fill every pending slot, the full-table case is quick to reach, along with the release of one slot and the load that then goes through. The 5-bit indices let the bench sweep every register as a source right after reset. Register 0 can be aimed at directly, and so can a completion that lands on the same register as a new load in the same cycle.

// File: rtl/scoreboard_pkg.sv
package scoreboard_pkg;
  localparam int unsigned SB_NUM_REGS    = 32;
  localparam int unsigned SB_MAX_PENDING = 4;
endpackage

// File: rtl/sb_lock_table.sv
module sb_lock_table #(
  parameter int unsigned NUM_REGS    = 32,
  parameter int unsigned MAX_PENDING = 4,
  localparam int unsigned IDX_W      = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    clr_idx,
  output logic [NUM_REGS-1:0] lock_q
);
  logic [NUM_REGS-1:0] lock_d;
  logic                lock_en;

  assign lock_en = set_en | clr_en;

  // Completion clears first, then a new lock is applied, so set wins.
  always_comb begin
    lock_d = lock_q;
    if (clr_en) lock_d[clr_idx] = 1'b0;
    if (set_en) lock_d[set_idx] = 1'b1;
    lock_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= '0;
    else if (lock_en) lock_q <= lock_d;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lock_q) <= MAX_PENDING); // R9
  AST_SET_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_idx != '0) |=> lock_q[$past(set_idx)]); // R8
  AST_CLR_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_idx == clr_idx)) |=> !lock_q[$past(clr_idx)]); // R6
  AST_R0_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q[0]); // R7
endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check #(
  parameter int unsigned NUM_REGS    = 32,
  parameter int unsigned MAX_PENDING = 4,
  localparam int unsigned IDX_W      = $clog2(NUM_REGS),
  localparam int unsigned CNT_W      = $clog2(NUM_REGS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                iss_valid,
  input  logic                iss_is_load,
  input  logic [IDX_W-1:0]    iss_dst,
  input  logic [IDX_W-1:0]    iss_src_a,
  input  logic [IDX_W-1:0]    iss_src_b,
  input  logic [NUM_REGS-1:0] lock_q,
  output logic                stall
);
  logic [CNT_W-1:0] pending_cnt;
  logic             hit_a;
  logic             hit_b;
  logic             hit_d;
  logic             full;

  always_comb begin
    pending_cnt = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      pending_cnt = pending_cnt + CNT_W'(lock_q[i]);
    end
  end

  assign hit_a = lock_q[iss_src_a];
  assign hit_b = lock_q[iss_src_b];
  assign hit_d = lock_q[iss_dst];
  assign full  = (32'(pending_cnt) >= MAX_PENDING);
  assign stall = iss_valid & (hit_a | hit_b | hit_d | (iss_is_load & full));

  AST_SRC_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_src_a != '0 && lock_q[iss_src_a]) |-> stall); // R4
  AST_SRC_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_src_b != '0 && lock_q[iss_src_b]) |-> stall); // R4
  AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && lock_q[iss_dst]) |-> stall); // R5
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !stall); // R10
endmodule

// File: rtl/load_lock_scoreboard.sv
module load_lock_scoreboard
  import scoreboard_pkg::*;
#(
  parameter int unsigned NUM_REGS    = SB_NUM_REGS,
  parameter int unsigned MAX_PENDING = SB_MAX_PENDING,
  localparam int unsigned IDX_W      = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic             iss_is_load,
  input  logic [IDX_W-1:0] iss_dst,
  input  logic [IDX_W-1:0] iss_src_a,
  input  logic [IDX_W-1:0] iss_src_b,
  input  logic             cpl_valid,
  input  logic [IDX_W-1:0] cpl_reg,
  output logic             stall
);
  logic [NUM_REGS-1:0] lock_q;
  logic                accept;
  logic                set_en;
  logic                clr_en;

  assign accept = iss_valid & ~stall;
  assign set_en = accept & iss_is_load & (iss_dst != '0);
  assign clr_en = cpl_valid & (cpl_reg != '0);

  sb_lock_table #(.NUM_REGS(NUM_REGS), .MAX_PENDING(MAX_PENDING)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (set_en),
    .set_idx (iss_dst),
    .clr_en  (clr_en),
    .clr_idx (cpl_reg),
    .lock_q  (lock_q)
  );

  sb_hazard_check #(.NUM_REGS(NUM_REGS), .MAX_PENDING(MAX_PENDING)) u_hazard (
    .clk         (clk),
    .rst_n       (rst_n),
    .iss_valid   (iss_valid),
    .iss_is_load (iss_is_load),
    .iss_dst     (iss_dst),
    .iss_src_a   (iss_src_a),
    .iss_src_b   (iss_src_b),
    .lock_q      (lock_q),
    .stall       (stall)
  );

  AST_STALLED_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !clr_en) |=> $stable(lock_q)); // R11
endmodule

// File: tb/tb_load_lock_scoreboard.sv
module tb_load_lock_scoreboard;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       iss_valid, iss_is_load, cpl_valid;
  logic [4:0] iss_dst, iss_src_a, iss_src_b, cpl_reg;
  logic       stall;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  load_lock_scoreboard dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_is_load(iss_is_load),
    .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .cpl_valid(cpl_valid), .cpl_reg(cpl_reg), .stall(stall)
  );

  task automatic drv(input logic v, input logic ld, input logic [4:0] d,
                     input logic [4:0] a, input logic [4:0] b,
                     input logic cv, input logic [4:0] cr);
    @(negedge clk);
    iss_valid = v; iss_is_load = ld; iss_dst = d; iss_src_a = a; iss_src_b = b;
    cpl_valid = cv; cpl_reg = cr;
    #1;
  endtask

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (stall !== exp) begin
      errors++;
      $display("FAIL %s: stall actual %b expected %b", tag, stall, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    iss_valid = 0; iss_is_load = 0; iss_dst = 0; iss_src_a = 0; iss_src_b = 0;
    cpl_valid = 0; cpl_reg = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    for (int r = 1; r < 32; r++) begin
      drv(1, 0, 5'(r), 5'(r), 5'(r), 0, 0);
      chk(0, "R1 reset unlocked");
    end
  endtask

  task automatic t_lock_use();
    do_reset();
    drv(1, 1, 5, 1, 2, 0, 0);  chk(0, "R2 load r5 accepted");
    drv(1, 0, 8, 5, 6, 0, 0);  chk(1, "R4 src_a locked / R2");
    drv(1, 0, 8, 6, 5, 0, 0);  chk(1, "R4 src_b locked");
    drv(1, 0, 5, 6, 7, 0, 0);  chk(1, "R5 dst locked");
    drv(1, 0, 8, 6, 7, 0, 0);  chk(0, "R3 independent flows");
    drv(0, 0, 5, 5, 5, 0, 0);  chk(0, "R10 no valid no stall");
    drv(1, 0, 8, 5, 6, 1, 5);  chk(1, "R10 completion same cycle still stalls");
    drv(1, 0, 8, 5, 6, 0, 0);  chk(0, "R6 completion released r5");
  endtask

  task automatic t_reg_zero();
    do_reset();
    drv(1, 1, 0, 3, 4, 0, 0);  chk(0, "R7 load r0 accepted");
    drv(1, 0, 0, 0, 0, 0, 0);  chk(0, "R7 r0 never stalls");
  endtask

  task automatic t_collision();
    do_reset();
    drv(1, 1, 9, 1, 2, 1, 9);  chk(0, "R8 load r9 with completion r9");
    drv(1, 0, 8, 9, 1, 0, 0);  chk(1, "R8 new lock wins");
  endtask

  task automatic t_limit();
    do_reset();
    for (int r = 1; r <= 4; r++) begin
      drv(1, 1, 5'(r), 20, 21, 0, 0);
      chk(0, "R9 filling pending slots");
    end
    drv(1, 1, 10, 20, 21, 0, 0); chk(1, "R9 fifth load stalls");
    drv(1, 1, 10, 20, 21, 0, 0); chk(1, "R9 fifth load still held");
    drv(1, 0, 11, 20, 21, 0, 0); chk(0, "R9 non-load passes when full");
    drv(1, 0, 12, 10, 21, 0, 0); chk(0, "R11 stalled load left r10 unlocked");
    drv(1, 1, 10, 20, 21, 1, 2); chk(1, "R9 release not seen same cycle");
    drv(1, 1, 10, 20, 21, 0, 0); chk(0, "R9 load issues after release");
    drv(1, 0, 12, 10, 21, 0, 0); chk(1, "R2 r10 now locked");
    drv(1, 0, 12, 2, 21, 0, 0);  chk(0, "R6 r2 released");
  endtask

  initial begin
    t_reset_state();
    t_lock_use();
    t_reg_zero();
    t_collision();
    t_limit();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule